// File: doc/BRIEF.md
# I2C Master Stuck-Bus Recovery Sequencer

This block sits between the transfer-start request of an I2C master and the logic that generates the START condition. When a transfer is requested in master mode, it looks at the SDA line. If SDA is high, it issues START straight away. If SDA is held low by a slave stuck mid-byte, it first leaves SDA released and toggles SCL. This lets the slave shift out its pending bits until SDA comes free.

Each recovery clock is one bit-clock tick low and one tick high, and SDA is sampled at the end of each high half. When SDA is seen high, SCL is held high for a further tick and START is then issued. If SDA is still low after the ninth recovery clock, the attempt is abandoned. In that case no START is driven, the request bit drops, and both the error flag and the start flag are raised. Both flags stay set until cleared by write-one-to-clear inputs.

Top module: `i2c_bus_recover`

## Requirements
- R1: After reset, scl_oe, sda_oe, xfer_pending, start_done, err_flag and start_flag are all 0.
- R2: A xfer_go pulse is accepted only while master_en is 1. Acceptance sets xfer_pending to 1. With master_en at 0, xfer_pending and scl_oe stay 0.
- R3: If sda_in is high when checked at the first tick after acceptance, no SCL pulse is driven. sda_oe (1 = SDA pulled low) rises while scl_oe is 0, is held for one tick, and start_done then pulses for one cycle together with xfer_pending falling.
- R4: While SDA is stuck low, scl_oe (1 = SCL pulled low) pulses with a low half of exactly one tick period each. sda_oe is never 1 while scl_oe is 1.
- R5: If an external device releases SDA during the k-th recovery clock (1 <= k <= 9), exactly k SCL pulses are driven and START follows.
- R6: After a successful recovery, SCL stays released for at least one tick period before sda_oe rises.
- R7: If SDA is still low at the end of the ninth clock's high half, sda_oe never rises and xfer_pending falls. err_flag and start_flag are both set in the same cycle, and start_done stays 0.
- R8: No request drives more than 9 SCL pulses, which is within the limit of ten.
- R9: A successful START sets start_flag and leaves err_flag at 0.
- R10: err_flag and start_flag stay at 1 until a cycle with err_clr or start_clr respectively at 1. That cycle clears them.
- R11: A xfer_go pulse while xfer_pending is 1 has no effect. The ongoing sequence keeps its pulse count and outcome, and xfer_pending is 0 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| master_en | input | 1 | Master mode enabled |
| xfer_go | input | 1 | Transfer start request pulse |
| tick | input | 1 | Prescaled bit-clock tick, one cycle wide |
| sda_in | input | 1 | Sampled SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low (START only) |
| xfer_pending | output | 1 | Request bit; high from acceptance to START or failure |
| start_done | output | 1 | One-cycle pulse when START has been issued |
| err_flag | output | 1 | Sticky recovery-failure flag |
| start_flag | output | 1 | Sticky start flag (success or failure) |
| err_clr | input | 1 | Write-one-to-clear for err_flag |
| start_clr | input | 1 | Write-one-to-clear for start_flag |

## Verification
The bench sweeps the number of SCL rising edges an emulated stuck slave waits before releasing SDA, from 0 to 12, plus a slave that never releases.

- A hold count of zero separates the direct START path from recovery.
- Counts of one to nine confirm that the pulse count tracks the release point exactly, and count nine marks the last successful pulse.
- Counts of ten and above must all give the same failure after nine pulses.

Further runs place a second request in the middle of a recovery and a request with master mode off.

// File: rtl/i2c_bc_pkg.sv
// Shared types for the bus recovery sequencer.
// Assumes: one tick period is the half-period of a recovery clock.
package i2c_bc_pkg;

    typedef enum logic [2:0] {
        BC_IDLE  = 3'd0,
        BC_CHECK = 3'd1,
        BC_LOW   = 3'd2,
        BC_HIGH  = 3'd3,
        BC_SETUP = 3'd4,
        BC_START = 3'd5
    } bc_state_e;

endpackage

// File: rtl/i2c_bc_counter.sv
// Counts recovery clocks issued for the current request.
// Assumes: clr and inc are never high in the same cycle.
module i2c_bc_counter #(
    parameter int LIMIT = 9,
    parameter int CW    = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic at_last
);

    logic [CW-1:0] cnt_q;

    // Pulse counter: cleared per request, bumped at each high-half end.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q <= '0;
        end else if (inc) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign at_last = (cnt_q == CW'(LIMIT - 1));

endmodule

// File: rtl/i2c_bc_seq.sv
// Sequencer: checks SDA, runs recovery clocks, issues START or fails.
// Assumes: tick is a single-cycle strobe; sda_in is already synchronised.
module i2c_bc_seq
    import i2c_bc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic master_en,
    input  logic xfer_go,
    input  logic tick,
    input  logic sda_in,
    input  logic at_last,
    output logic cnt_clr,
    output logic cnt_inc,
    output logic scl_oe,
    output logic sda_oe,
    output logic active,
    output logic ok_pulse,
    output logic fail_pulse,
    output logic done_q
);

    bc_state_e state_q, state_d;

    // Next-state and strobe decode.
    always_comb begin
        state_d    = state_q;
        cnt_clr    = 1'b0;
        cnt_inc    = 1'b0;
        ok_pulse   = 1'b0;
        fail_pulse = 1'b0;
        case (state_q)
            BC_IDLE: begin
                if (xfer_go && master_en) begin
                    state_d = BC_CHECK;
                    cnt_clr = 1'b1;
                end
            end
            BC_CHECK: begin
                if (tick) state_d = sda_in ? BC_START : BC_LOW;
            end
            BC_LOW: begin
                if (tick) state_d = BC_HIGH;
            end
            BC_HIGH: begin
                if (tick) begin
                    cnt_inc = 1'b1;
                    if (sda_in) begin
                        state_d = BC_SETUP;
                    end else if (at_last) begin
                        state_d    = BC_IDLE;
                        fail_pulse = 1'b1;
                    end else begin
                        state_d = BC_LOW;
                    end
                end
            end
            BC_SETUP: begin
                if (tick) state_d = BC_START;
            end
            BC_START: begin
                if (tick) begin
                    state_d  = BC_IDLE;
                    ok_pulse = 1'b1;
                end
            end
            default: state_d = BC_IDLE;
        endcase
    end

    // State register and registered completion strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= BC_IDLE;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= ok_pulse;
        end
    end

    assign scl_oe = (state_q == BC_LOW);
    assign sda_oe = (state_q == BC_START);
    assign active = (state_q != BC_IDLE);

endmodule

// File: rtl/i2c_bc_flags.sv
// Sticky error and start flags with write-one-to-clear; a set wins over a clear.
// Assumes: set strobes are single-cycle.
module i2c_bc_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic ok_pulse,
    input  logic fail_pulse,
    input  logic err_clr,
    input  logic start_clr,
    output logic err_flag,
    output logic start_flag
);

    // Error flag: set on failed recovery only.
    always_ff @(posedge clk) begin
        if (!rst_n)          err_flag <= 1'b0;
        else if (fail_pulse) err_flag <= 1'b1;
        else if (err_clr)    err_flag <= 1'b0;
    end

    // Start flag: set on any START outcome.
    always_ff @(posedge clk) begin
        if (!rst_n)                      start_flag <= 1'b0;
        else if (ok_pulse || fail_pulse) start_flag <= 1'b1;
        else if (start_clr)              start_flag <= 1'b0;
    end

endmodule

// File: rtl/i2c_bus_recover.sv
// Top: stuck-SDA recovery in front of an I2C master START generator.
// Assumes: master mode selected by master_en; open-drain pads outside.
module i2c_bus_recover #(
    parameter int CLR_PULSES = 9,
    parameter int MAX_PULSES = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic master_en,
    input  logic xfer_go,
    input  logic tick,
    input  logic sda_in,
    output logic scl_oe,
    output logic sda_oe,
    output logic xfer_pending,
    output logic start_done,
    output logic err_flag,
    output logic start_flag,
    input  logic err_clr,
    input  logic start_clr
);

    localparam int CW = $clog2(MAX_PULSES + 1);

    logic cnt_clr, cnt_inc, at_last, ok_pulse, fail_pulse;

    i2c_bc_counter #(.LIMIT(CLR_PULSES), .CW(CW)) u_cnt (
        .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .inc(cnt_inc), .at_last(at_last)
    );

    i2c_bc_seq u_seq (
        .clk(clk), .rst_n(rst_n), .master_en(master_en), .xfer_go(xfer_go),
        .tick(tick), .sda_in(sda_in), .at_last(at_last),
        .cnt_clr(cnt_clr), .cnt_inc(cnt_inc), .scl_oe(scl_oe), .sda_oe(sda_oe),
        .active(xfer_pending), .ok_pulse(ok_pulse), .fail_pulse(fail_pulse),
        .done_q(start_done)
    );

    i2c_bc_flags u_flags (
        .clk(clk), .rst_n(rst_n), .ok_pulse(ok_pulse), .fail_pulse(fail_pulse),
        .err_clr(err_clr), .start_clr(start_clr),
        .err_flag(err_flag), .start_flag(start_flag)
    );

endmodule

// File: rtl/i2c_bus_recover_chk.sv
// Checker bound to the top: protocol properties seen at its ports.
module i2c_bus_recover_chk #(
    parameter int CLR_PULSES = 9,
    parameter int MAX_PULSES = 10
) (
    input logic clk,
    input logic rst_n,
    input logic master_en,
    input logic xfer_go,
    input logic scl_oe,
    input logic sda_oe,
    input logic xfer_pending,
    input logic start_done,
    input logic err_flag,
    input logic start_flag,
    input logic err_clr,
    input logic start_clr
);

    logic [7:0] pulses_q;
    logic       scl_prev_q;

    // Count SCL pulses driven within one request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pulses_q   <= '0;
            scl_prev_q <= 1'b0;
        end else begin
            scl_prev_q <= scl_oe;
            if (!xfer_pending)             pulses_q <= '0;
            else if (scl_oe && !scl_prev_q) pulses_q <= pulses_q + 8'd1;
        end
    end

    a_r8_pulse_bound: assert property (@(posedge clk) disable iff (!rst_n)
        pulses_q <= 8'(CLR_PULSES) && pulses_q <= 8'(MAX_PULSES));

    a_r4_sda_free_while_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        scl_oe |-> !sda_oe);

    a_r6_start_setup: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> (!scl_oe && !$past(scl_oe)));

    a_r7_fail_flags: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_flag) |-> (start_flag && !xfer_pending && !start_done));

    a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flag && !err_clr) |=> err_flag);

    a_r10_start_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (start_flag && !start_clr) |=> start_flag);

    a_r2_master_only: assert property (@(posedge clk) disable iff (!rst_n)
        (!xfer_pending && xfer_go && !master_en) |=> !xfer_pending);

    a_r9_done_sets_start: assert property (@(posedge clk) disable iff (!rst_n)
        start_done |-> start_flag);

endmodule

bind i2c_bus_recover i2c_bus_recover_chk #(
    .CLR_PULSES(CLR_PULSES), .MAX_PULSES(MAX_PULSES)
) u_chk (
    .clk(clk), .rst_n(rst_n), .master_en(master_en), .xfer_go(xfer_go),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .xfer_pending(xfer_pending),
    .start_done(start_done), .err_flag(err_flag), .start_flag(start_flag),
    .err_clr(err_clr), .start_clr(start_clr)
);

// File: tb/test_i2c_bus_recover.sv
// Bench: sweeps the stuck-slave release point and checks outcome and timing.
module test_i2c_bus_recover;

    localparam int TP = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic master_en = 1'b0, xfer_go = 1'b0, tick = 1'b0;
    logic err_clr = 1'b0, start_clr = 1'b0;
    logic ext_low = 1'b0;
    logic scl_oe, sda_oe, xfer_pending, start_done, err_flag, start_flag;
    logic sda_in;
    int   checks = 0, fails = 0, tcnt = 0;

    assign sda_in = ~(sda_oe | ext_low);

    always #5 clk = ~clk;

    i2c_bus_recover i_i2c_bus_recover (
        .clk(clk), .rst_n(rst_n), .master_en(master_en), .xfer_go(xfer_go),
        .tick(tick), .sda_in(sda_in), .scl_oe(scl_oe), .sda_oe(sda_oe),
        .xfer_pending(xfer_pending), .start_done(start_done),
        .err_flag(err_flag), .start_flag(start_flag),
        .err_clr(err_clr), .start_clr(start_clr)
    );

    // Tick strobe every TP cycles.
    always @(negedge clk) begin
        if (!rst_n) tcnt = 0;
        else        tcnt = (tcnt + 1) % TP;
        tick = (tcnt == 0) && rst_n;
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_flags();
        @(negedge clk); err_clr = 1'b1; start_clr = 1'b1;
        @(negedge clk); err_clr = 1'b0; start_clr = 1'b0;
        chk("R10 cleared err", int'(err_flag), 0);
        chk("R10 cleared start", int'(start_flag), 0);
    endtask

    // One request against a slave that releases SDA after hold_n SCL rises.
    task automatic run_case(input int hold_n, input bit mid_go);
        int  rises = 0, pulses = 0, low_run = 0, high_run = 0, setup = -1;
        int  bad_low = 0, bad_overlap = 0, done_seen = 0, cyc = 0;
        bit  prev_oe = 1'b0, prev_sda = 1'b0;
        bit  exp_ok = (hold_n <= 9);
        int  exp_p = (hold_n <= 9) ? hold_n : 9;
        ext_low = (hold_n > 0);
        @(negedge clk); xfer_go = 1'b1;
        @(negedge clk); xfer_go = 1'b0;
        chk("R2 accepted", int'(xfer_pending), 1);
        while (xfer_pending && cyc < 2000) begin
            @(negedge clk);
            cyc++;
            if (mid_go && pulses == 3) xfer_go = 1'b1; else xfer_go = 1'b0;
            if (prev_oe && !scl_oe) begin
                rises++;
                if (low_run != TP) bad_low++;
            end
            if (!prev_oe && scl_oe) begin pulses++; low_run = 0; end
            if (scl_oe) begin low_run++; high_run = 0; end else high_run++;
            if (scl_oe && sda_oe) bad_overlap++;
            if (sda_oe && !prev_sda) setup = high_run - 1;
            if (start_done) done_seen++;
            ext_low = (rises < hold_n);
            prev_oe = scl_oe;
            prev_sda = sda_oe;
        end
        xfer_go = 1'b0;
        chk("R11/R2 pending ends 0", int'(xfer_pending), 0);
        chk("R5/R7/R8 pulse count", pulses, exp_p);
        chk("R4 low half one tick", bad_low, 0);
        chk("R4 no SDA drive while SCL low", bad_overlap, 0);
        chk("R9/R7 err_flag", int'(err_flag), exp_ok ? 0 : 1);
        chk("R9/R7 start_flag", int'(start_flag), 1);
        chk("R3/R7 start_done", done_seen, exp_ok ? 1 : 0);
        if (!exp_ok) chk("R7 no START", setup, -1);
        else if (hold_n > 0) chk("R6 setup >= tick", int'(setup >= TP), 1);
        else chk("R3 direct start, no pulses", int'(setup >= 0), 1);
        repeat (20) @(negedge clk);
        chk("R10 err sticky", int'(err_flag), exp_ok ? 0 : 1);
        chk("R10 start sticky", int'(start_flag), 1);
        clear_flags();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 scl_oe", int'(scl_oe), 0);
        chk("R1 sda_oe", int'(sda_oe), 0);
        chk("R1 pending", int'(xfer_pending), 0);
        chk("R1 done", int'(start_done), 0);
        chk("R1 flags", int'(err_flag | start_flag), 0);
        xfer_go = 1'b1;
        @(negedge clk); xfer_go = 1'b0;
        repeat (20) begin
            @(negedge clk);
            if (xfer_pending || scl_oe) chk("R2 ignored without master", 1, 0);
        end
        chk("R2 no pending without master", int'(xfer_pending), 0);
        master_en = 1'b1;
        for (int h = 0; h <= 12; h++) run_case(h, 1'b0);
        run_case(100, 1'b0);
        run_case(100, 1'b1);
        run_case(5, 1'b1);
        ext_low = 1'b0;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule